// File: doc/BRIEF.md
# Compressed Sparse Matrix-Vector Engine

This block multiplies a sparse matrix by a sparse vector without spending a cycle on any zero element. The matrix lives in five internal arrays that together form a two-level coordinate tree. A top-level pair of bounds selects the list of occupied rows. Each occupied row owns a half-open range of column coordinates, and each column coordinate sits beside its value. The vector arrives as a stream of (index, value) pairs in ascending index order and is kept in a small buffer. A start pulse makes the engine walk every occupied row in stored order. For each row it merges the row's column coordinates against the vector indices with two pointers. It multiplies and accumulates only where the two coordinates are equal. It then offers one (row, sum) result on a valid/ready output.

The walk is a five-state machine. `ST_IDLE` accepts matrix writes, vector pushes and start, and moves to `ST_ROW` on start. `ST_ROW` fetches the current row's coordinate and column bounds. From there it goes to `ST_DONE` when the row list is exhausted. It stays in `ST_ROW` (advancing the row pointer) when the row's column range is empty, and otherwise enters `ST_MERGE`. `ST_MERGE` advances the smaller-coordinate pointer, or both on a match with one multiply-accumulate. It goes to `ST_EMIT` when either operand runs out. `ST_EMIT` holds the result until `out_ready` and then returns to `ST_ROW` for the next row. `ST_DONE` raises `done` for one cycle, empties the vector buffer and returns to `ST_IDLE`.

Top module: `spmv_engine`

## Requirements
- R1: The matrix is written through `mat_we`/`mat_sel`/`mat_addr`/`mat_wdata`, with `mat_sel` codes 0 = row bounds, 1 = row coordinates, 2 = column bounds, 3 = column coordinates, 4 = values. Row-bound entries 0 and 1 give the half-open range of row-list positions to walk. Column-bound entries k and k+1 give the half-open range of nonzeros for row-list position k. A 4x4 matrix with three nonzeros in two rows is fully described by 13 written words.
- R2: Each emitted sum equals the dot product of that row with the vector, with products formed only where the column coordinate and the vector index are equal.
- R3: A row-list position whose column range is empty produces no result.
- R4: A nonempty row that shares no coordinate with the vector produces a result with sum 0.
- R5: A run with no vector pairs pushed (an all-zero vector) produces sum 0 for every nonempty row.
- R6: Results come out one per nonempty row, in stored row-list order (ascending row coordinates).
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_row` and `out_sum` hold steady.
- R8: `done` is high for exactly one cycle after the last result is accepted, or right after start when the row list is empty, and never together with `out_valid`.
- R9: A start pulse while a run is in progress is ignored; it neither restarts nor adds results.
- R10: After reset, `out_valid` and `done` are low and stay low until start.
- R11: Values are 16-bit two's complement and each row accumulates into a 32-bit two's-complement sum.
- R12: The vector buffer is emptied when `done` fires, so each run uses only pairs pushed since the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mat_we | input | 1 | Matrix array write strobe |
| mat_sel | input | 3 | Target array code (see R1) |
| mat_addr | input | NP_W | Word address inside the selected array |
| mat_wdata | input | 16 | Word written (bounds, coordinate or signed value) |
| vec_valid | input | 1 | Push one vector pair (accepted in idle only) |
| vec_idx | input | IDX_W | Vector pair coordinate, ascending per run |
| vec_val | input | 16 | Vector pair signed value |
| start | input | 1 | Begin a walk (pulse) |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Result accepted when high with out_valid |
| out_row | output | IDX_W | Row coordinate of the result |
| out_sum | output | 32 | Signed row sum |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench targets empty column ranges in the middle of the row list: a design that does not skip them emits a stray zero row or stalls. It targets rows with no shared coordinate and an empty vector, where a merge that tests the pointers too late would read past the buffer and accumulate garbage. It stalls `out_ready` and pulses start mid-run, which exposes a result that changes under back-pressure or a walk that restarts. Extreme-value products catch narrow or unsigned multiplication, and a second run without new pushes catches a vector buffer that is not emptied.

// File: rtl/spmv_pkg.sv
package spmv_pkg;
    localparam int VAL_W = 16;
    localparam int ACC_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_MERGE,
        ST_EMIT,
        ST_DONE
    } walk_state_e;

    typedef enum logic [2:0] {
        SEL_ROW_BND = 3'd0,
        SEL_ROW_CRD = 3'd1,
        SEL_COL_BND = 3'd2,
        SEL_COL_CRD = 3'd3,
        SEL_VALUE   = 3'd4
    } array_sel_e;
endpackage

// File: rtl/spmv_store.sv
module spmv_store
    import spmv_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int RP_W  = 4,
    parameter int NP_W  = 7
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [2:0]              sel,
    input  logic [NP_W-1:0]         addr,
    input  logic [VAL_W-1:0]        wdata,
    input  logic [RP_W-1:0]         rd_row,
    input  logic [NP_W-1:0]         rd_nz,
    output logic [RP_W-1:0]         row_lo,
    output logic [RP_W-1:0]         row_hi,
    output logic [IDX_W-1:0]        row_coord,
    output logic [NP_W-1:0]         col_lo,
    output logic [NP_W-1:0]         col_hi,
    output logic [IDX_W-1:0]        col_coord,
    output logic signed [VAL_W-1:0] nz_value
);
    localparam int ROW_DEPTH = 2 ** RP_W;
    localparam int NZ_DEPTH  = 2 ** NP_W;

    logic [RP_W-1:0]  row_bnd_q [2];
    logic [IDX_W-1:0] row_crd_q [ROW_DEPTH];
    logic [NP_W-1:0]  col_bnd_q [ROW_DEPTH];
    logic [IDX_W-1:0] col_crd_q [NZ_DEPTH];
    logic [VAL_W-1:0] value_q   [NZ_DEPTH];

    logic [RP_W-1:0] row_addr;
    logic [RP_W-1:0] rd_row_nx;

    assign row_addr  = addr[RP_W-1:0];
    assign rd_row_nx = rd_row + 1'b1;

    always_ff @(posedge clk) begin
        if (we) begin
            unique case (array_sel_e'(sel))
                SEL_ROW_BND: row_bnd_q[addr[0]] <= wdata[RP_W-1:0];
                SEL_ROW_CRD: row_crd_q[row_addr] <= wdata[IDX_W-1:0];
                SEL_COL_BND: col_bnd_q[row_addr] <= wdata[NP_W-1:0];
                SEL_COL_CRD: col_crd_q[addr] <= wdata[IDX_W-1:0];
                SEL_VALUE:   value_q[addr] <= wdata;
                default: ;
            endcase
        end
    end

    assign row_lo    = row_bnd_q[0];
    assign row_hi    = row_bnd_q[1];
    assign row_coord = row_crd_q[rd_row];
    assign col_lo    = col_bnd_q[rd_row];
    assign col_hi    = col_bnd_q[rd_row_nx];
    assign col_coord = col_crd_q[rd_nz];
    assign nz_value  = value_q[rd_nz];
endmodule

// File: rtl/spmv_vecbuf.sv
module spmv_vecbuf
    import spmv_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int VEC_CAP = 16,
    parameter int VP_W    = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push,
    input  logic [IDX_W-1:0]        push_idx,
    input  logic [VAL_W-1:0]        push_val,
    input  logic                    clr,
    input  logic [VP_W-1:0]         rd_ptr,
    output logic [VP_W-1:0]         count,
    output logic [IDX_W-1:0]        rd_idx,
    output logic signed [VAL_W-1:0] rd_val
);
    localparam int DEPTH = 2 ** VP_W;

    logic [IDX_W-1:0] idx_q [DEPTH];
    logic [VAL_W-1:0] val_q [DEPTH];
    logic [VP_W-1:0]  count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (push && (count_q < VP_W'(VEC_CAP))) begin
            idx_q[count_q] <= push_idx;
            val_q[count_q] <= push_val;
            count_q        <= count_q + 1'b1;
        end
    end

    assign count  = count_q;
    assign rd_idx = idx_q[rd_ptr];
    assign rd_val = val_q[rd_ptr];
endmodule

// File: rtl/spmv_mac.sv
module spmv_mac
    import spmv_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic signed [VAL_W-1:0] op_a,
    input  logic signed [VAL_W-1:0] op_b,
    output logic signed [ACC_W-1:0] acc
);
    logic signed [ACC_W-1:0] product;

    assign product = ACC_W'(op_a) * ACC_W'(op_b);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + product;
        end
    end
endmodule

// File: rtl/spmv_engine.sv
module spmv_engine
    import spmv_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int ROW_CAP = 8,
    parameter int NNZ_CAP = 64,
    parameter int VEC_CAP = 16,
    localparam int RP_W   = $clog2(ROW_CAP + 1),
    localparam int NP_W   = $clog2(NNZ_CAP + 1),
    localparam int VP_W   = $clog2(VEC_CAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mat_we,
    input  logic [2:0]       mat_sel,
    input  logic [NP_W-1:0]  mat_addr,
    input  logic [15:0]      mat_wdata,
    input  logic             vec_valid,
    input  logic [IDX_W-1:0] vec_idx,
    input  logic [15:0]      vec_val,
    input  logic             start,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [IDX_W-1:0] out_row,
    output logic [31:0]      out_sum,
    output logic             done
);
    walk_state_e st, st_nxt;

    logic [RP_W-1:0]  row_ptr, row_end;
    logic [NP_W-1:0]  nz_ptr, nz_end;
    logic [VP_W-1:0]  vec_ptr;
    logic [IDX_W-1:0] row_id;

    logic [RP_W-1:0]         row_lo, row_hi;
    logic [IDX_W-1:0]        row_coord, col_coord, v_idx;
    logic [NP_W-1:0]         col_lo, col_hi;
    logic signed [VAL_W-1:0] nz_value, v_val;
    logic [VP_W-1:0]         v_count;
    logic signed [ACC_W-1:0] acc;

    logic busy, mac_clr, mac_en, vec_push, vec_clr;
    logic rows_over, row_empty, merge_end, crd_lt, crd_gt;

    spmv_store #(.IDX_W(IDX_W), .RP_W(RP_W), .NP_W(NP_W)) store_i (
        .clk       (clk),
        .we        (mat_we),
        .sel       (mat_sel),
        .addr      (mat_addr),
        .wdata     (mat_wdata),
        .rd_row    (row_ptr),
        .rd_nz     (nz_ptr),
        .row_lo    (row_lo),
        .row_hi    (row_hi),
        .row_coord (row_coord),
        .col_lo    (col_lo),
        .col_hi    (col_hi),
        .col_coord (col_coord),
        .nz_value  (nz_value)
    );

    spmv_vecbuf #(.IDX_W(IDX_W), .VEC_CAP(VEC_CAP), .VP_W(VP_W)) vec_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (vec_push),
        .push_idx (vec_idx),
        .push_val (vec_val),
        .clr      (vec_clr),
        .rd_ptr   (vec_ptr),
        .count    (v_count),
        .rd_idx   (v_idx),
        .rd_val   (v_val)
    );

    spmv_mac mac_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mac_clr),
        .en    (mac_en),
        .op_a  (nz_value),
        .op_b  (v_val),
        .acc   (acc)
    );

    assign rows_over = (row_ptr == row_end);
    assign row_empty = (col_lo == col_hi);
    assign merge_end = (nz_ptr == nz_end) || (vec_ptr == v_count);
    assign crd_lt    = (col_coord < v_idx);
    assign crd_gt    = (col_coord > v_idx);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // Transitions
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (start) st_nxt = ST_ROW;
            ST_ROW: begin
                if (rows_over)      st_nxt = ST_DONE;
                else if (row_empty) st_nxt = ST_ROW;
                else                st_nxt = ST_MERGE;
            end
            ST_MERGE: if (merge_end) st_nxt = ST_EMIT;
            ST_EMIT:  if (out_ready) st_nxt = ST_ROW;
            ST_DONE:  st_nxt = ST_IDLE;
            default:  st_nxt = ST_IDLE;
        endcase
    end

    // Outputs and strobes
    always_comb begin
        out_valid = (st == ST_EMIT);
        done      = (st == ST_DONE);
        busy      = (st != ST_IDLE);
        mac_clr   = (st == ST_ROW);
        mac_en    = (st == ST_MERGE) && !merge_end && !crd_lt && !crd_gt;
        vec_push  = vec_valid && (st == ST_IDLE);
        vec_clr   = (st == ST_DONE);
        out_row   = row_id;
        out_sum   = acc;
    end

    // Walk pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_ptr <= '0;
            row_end <= '0;
            nz_ptr  <= '0;
            nz_end  <= '0;
            vec_ptr <= '0;
            row_id  <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        row_ptr <= row_lo;
                        row_end <= row_hi;
                    end
                end
                ST_ROW: begin
                    if (!rows_over) begin
                        row_id  <= row_coord;
                        nz_ptr  <= col_lo;
                        nz_end  <= col_hi;
                        vec_ptr <= '0;
                        if (row_empty) row_ptr <= row_ptr + 1'b1;
                    end
                end
                ST_MERGE: begin
                    if (!merge_end) begin
                        if (crd_lt) begin
                            nz_ptr <= nz_ptr + 1'b1;
                        end else if (crd_gt) begin
                            vec_ptr <= vec_ptr + 1'b1;
                        end else begin
                            nz_ptr  <= nz_ptr + 1'b1;
                            vec_ptr <= vec_ptr + 1'b1;
                        end
                    end
                end
                ST_EMIT: begin
                    if (out_ready) row_ptr <= row_ptr + 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/spmv_engine_chk.sv
module spmv_engine_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             out_valid,
    input logic             out_ready,
    input logic [IDX_W-1:0] out_row,
    input logic [31:0]      out_sum,
    input logic             done
);
    logic             seen_q;
    logic [IDX_W-1:0] last_row_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q     <= 1'b0;
            last_row_q <= '0;
        end else if (done) begin
            seen_q <= 1'b0;
        end else if (out_valid && out_ready) begin
            seen_q     <= 1'b1;
            last_row_q <= out_row;
        end
    end

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_row) && $stable(out_sum)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid); // R8
    AST_ROW_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && out_valid |-> out_row > last_row_q); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && start |=> busy); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid && !done); // R10
endmodule

bind spmv_engine spmv_engine_chk #(.IDX_W(IDX_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_row   (out_row),
    .out_sum   (out_sum),
    .done      (done)
);

// File: tb/spmv_engine_tb_top.sv
`timescale 1ns/1ps
module spmv_engine_tb_top;
    localparam int IDX_W = 8;
    localparam int NP_W  = 7;
    localparam int DIM   = 8;
    // seed, matrix density %, vector density %, stall %
    localparam int NCASE = 6;
    localparam int CASES [NCASE][4] = '{
        '{11, 30, 50, 0}, '{23, 60, 40, 25}, '{37, 15, 80, 50},
        '{41, 90, 90, 10}, '{53, 45, 20, 0}, '{67, 70, 60, 40}};

    logic clk = 1'b0, rst_n = 1'b0;
    logic mat_we = 1'b0;
    logic [2:0] mat_sel = '0;
    logic [NP_W-1:0] mat_addr = '0;
    logic [15:0] mat_wdata = '0;
    logic vec_valid = 1'b0;
    logic [IDX_W-1:0] vec_idx = '0;
    logic [15:0] vec_val = '0;
    logic start = 1'b0, out_ready = 1'b0;
    logic out_valid, done;
    logic [IDX_W-1:0] out_row;
    logic [31:0] out_sum;

    int checks = 0, fails = 0;
    int A [DIM][DIM];
    int x [DIM];
    int exp_row [DIM+2], got_row [DIM+2];
    int exp_sum [DIM+2], got_sum [DIM+2];
    int nexp, ngot, words, done_cnt;
    int unsigned seed;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    spmv_engine dut_i (
        .clk(clk), .rst_n(rst_n), .mat_we(mat_we), .mat_sel(mat_sel),
        .mat_addr(mat_addr), .mat_wdata(mat_wdata), .vec_valid(vec_valid),
        .vec_idx(vec_idx), .vec_val(vec_val), .start(start),
        .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
        .out_sum(out_sum), .done(done));

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) & 32'h7fff);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic wr(input int sel, input int addr, input int data);
        mat_we = 1'b1; mat_sel = 3'(sel); mat_addr = NP_W'(addr); mat_wdata = 16'(data);
        @(negedge clk);
        mat_we = 1'b0;
        words++;
    endtask

    task automatic push(input int idx, input int val);
        vec_valid = 1'b1; vec_idx = IDX_W'(idx); vec_val = 16'(val);
        @(negedge clk);
        vec_valid = 1'b0;
    endtask

    task automatic clear_dense();
        for (int i = 0; i < DIM; i++) begin
            x[i] = 0;
            for (int j = 0; j < DIM; j++) A[i][j] = 0;
        end
    endtask

    // Build the coordinate tree from A, push nonzero x, compute expected rows
    task automatic load_dense(input bit push_vec);
        int nr = 0, nz = 0;
        longint s;
        words = 0; nexp = 0;
        wr(2, 0, 0);
        for (int i = 0; i < DIM; i++) begin
            int cnt = 0;
            for (int j = 0; j < DIM; j++) if (A[i][j] != 0) cnt++;
            if (cnt > 0) begin
                wr(1, nr, i);
                s = 0;
                for (int j = 0; j < DIM; j++) begin
                    if (A[i][j] != 0) begin
                        wr(3, nz, j); wr(4, nz, A[i][j]); nz++;
                        if (push_vec) s += longint'(A[i][j]) * longint'(x[j]);
                    end
                end
                nr++;
                wr(2, nr, nz);
                exp_row[nexp] = i; exp_sum[nexp] = int'(s); nexp++;
            end
        end
        wr(0, 0, 0); wr(0, 1, nr);
        if (push_vec)
            for (int j = 0; j < DIM; j++) if (x[j] != 0) push(j, x[j]);
    endtask

    task automatic run(input int stall_pct, input bit poke_start);
        int cyc = 0;
        bit poked = 1'b0;
        ngot = 0; done_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (done_cnt == 0 && cyc < 5000) begin
            out_ready = ((rnd() % 100) >= stall_pct);
            start = 1'b0;
            if (poke_start && !poked && out_valid && !out_ready) begin
                start = 1'b1; poked = 1'b1;
            end
            if (out_valid && out_ready && ngot < DIM + 2) begin
                got_row[ngot] = int'(out_row); got_sum[ngot] = int'($signed(out_sum)); ngot++;
            end
            if (done) begin
                done_cnt++;
                check(!out_valid, "R8 done with valid", out_valid, 0);
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(cyc < 5000, "R8 run finished", cyc, 5000);
        check(!done, "R8 done one cycle", done, 0);
        out_ready = 1'b1;
    endtask

    task automatic compare(input string req);
        check(ngot == nexp, {req, " result count"}, ngot, nexp);
        for (int k = 0; k < nexp && k < ngot; k++) begin
            check(got_row[k] == exp_row[k], {req, " row"}, got_row[k], exp_row[k]);
            check(got_sum[k] == exp_sum[k], {req, " sum"}, got_sum[k], exp_sum[k]);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        seed = 1;
        repeat (3) @(negedge clk);
        check(!out_valid && !done, "R10 reset outputs", {out_valid, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!out_valid && !done, "R10 idle before start", {out_valid, done}, 0);

        // Random table walk against dense reference: R2, R6, R7
        for (int c = 0; c < NCASE; c++) begin
            seed = CASES[c][0];
            clear_dense();
            for (int i = 0; i < DIM; i++)
                for (int j = 0; j < DIM; j++)
                    if ((rnd() % 100) < CASES[c][1]) begin
                        A[i][j] = (rnd() % 2001) - 1000;
                        if (A[i][j] == 0) A[i][j] = 1;
                    end
            for (int j = 0; j < DIM; j++)
                if ((rnd() % 100) < CASES[c][2]) begin
                    x[j] = (rnd() % 2001) - 1000;
                    if (x[j] == 0) x[j] = -1;
                end
            load_dense(1'b1);
            run(CASES[c][3], 1'b0);
            compare("R2 R6 R7 random");
        end

        // R1: 4x4, three nonzeros in two rows, 13 words
        clear_dense();
        A[1][0] = 5; A[1][3] = -2; A[3][2] = 7;
        x[0] = 3; x[2] = 4; x[3] = 10;
        load_dense(1'b1);
        check(words == 13, "R1 word count", words, 13);
        exp_sum[0] = -5; exp_sum[1] = 28;
        run(50, 1'b1);   // R9: start poked during a stall
        compare("R1 R9 small tree");
        check(done_cnt == 1, "R9 single done", done_cnt, 1);
        repeat (4) begin
            check(!out_valid && !done, "R9 no restart", {out_valid, done}, 0);
            @(negedge clk);
        end

        // R5/R12: rerun without pushes, buffer was emptied
        run(0, 1'b0);
        exp_sum[0] = 0; exp_sum[1] = 0;
        compare("R5 R12 empty vector");

        // R3: middle row-list position with empty column range
        words = 0;
        wr(0, 0, 0); wr(0, 1, 3);
        wr(1, 0, 0); wr(1, 1, 2); wr(1, 2, 5);
        wr(2, 0, 0); wr(2, 1, 1); wr(2, 2, 1); wr(2, 3, 2);
        wr(3, 0, 1); wr(4, 0, 6); wr(3, 1, 4); wr(4, 1, -3);
        push(1, 2); push(4, 5);
        nexp = 2; exp_row[0] = 0; exp_sum[0] = 12; exp_row[1] = 5; exp_sum[1] = -15;
        run(0, 1'b0);
        compare("R3 empty range skipped");

        // R4: nonempty row without overlap
        wr(0, 0, 0); wr(0, 1, 1); wr(1, 0, 4);
        wr(2, 0, 0); wr(2, 1, 2);
        wr(3, 0, 1); wr(4, 0, 9); wr(3, 1, 3); wr(4, 1, 8);
        push(0, 7); push(2, 7); push(5, 7);
        nexp = 1; exp_row[0] = 4; exp_sum[0] = 0;
        run(0, 1'b0);
        compare("R4 no overlap");

        // R11: extreme signed values
        wr(0, 0, 0); wr(0, 1, 1); wr(1, 0, 7);
        wr(2, 0, 0); wr(2, 1, 2);
        wr(3, 0, 0); wr(4, 0, -32768); wr(3, 1, 1); wr(4, 1, -32768);
        push(0, -32768); push(1, 32767);
        nexp = 1; exp_row[0] = 7; exp_sum[0] = 32768;
        run(30, 1'b0);
        compare("R11 signed extremes");

        // R8: empty row list gives done without results
        wr(0, 0, 0); wr(0, 1, 0);
        nexp = 0;
        run(0, 1'b0);
        compare("R8 empty list");
        check(done_cnt == 1, "R8 done count", done_cnt, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule